// File: doc/BRIEF.md
# Windowed Indirect Register Access Bridge

This bridge turns one host request carrying a 32-bit indirect register address into a short series of transfers on a narrow internal register bus. The upper twelve address bits pick a segment. A 64-entry segment map turns that segment into a base value, and some entries in the map are holes. The bridge takes a hardware semaphore and writes the window register with the base combined with address bits 19:16. It then reads the window register back until it returns the value just written. Only after that match does it issue the real read or write through a fixed aperture. It then releases the semaphore and acknowledges the host with the read data and an error flag.

Only one request is in flight at a time. A request is taken only while the bridge is idle. The controller is a single state machine with these states:

- ST_IDLE: waits for `host_req`.
- ST_DECODE: checks the segment and builds the window value. It goes to ST_LOCK when the segment is valid, and to ST_DONE with an error when it is not.
- ST_LOCK: holds `sem_acq` until `sem_rsp`. It goes to ST_WIN_WR when the lock is granted, and to ST_DONE with an error when it is denied.
- ST_WIN_WR: writes the window register, then goes to ST_WIN_RD.
- ST_WIN_RD: reads the window register back.
  - On a match it goes to ST_DATA.
  - On a miss with attempts left it goes to ST_WAIT.
  - On a miss at the last attempt it goes to ST_UNLOCK with an error.
- ST_WAIT: idles for the poll gap, then goes back to ST_WIN_RD.
- ST_DATA: performs the aperture access, then goes to ST_UNLOCK.
- ST_UNLOCK: pulses `sem_rel` and goes to ST_DONE.
- ST_DONE: pulses `host_ack` and returns to ST_IDLE.

Top module: `ind_win_bridge`

## Requirements
- R1: A request whose segment index (address bits 31:20) is above 0x3F ends with `host_err`=1, with no bus transfer and no semaphore request.
- R2: Segment map entry i is a hole when i is 0 or when i modulo 8 is 7. A hole ends the request like R1. Any other entry has base 0x3000_0000 | (i << 20).
- R3: The first bus transfer is a write of base | (address bits 19:16 << 16) to the window register at `WIN_ADDR` (default 0x0013_0000). It happens after the lock is granted and before any data access.
- R4: The window register is read back until it equals the written value. There are at most `MAX_TRIES` reads, with `POLL_WAIT` idle cycles between reads. If no read matches, the request ends with `host_err`=1 and no data access.
- R5: The data access uses bus address (address bits 15:0) | 0x001E_0000. A write carries `host_wdata`. A read returns the bus data on `host_rdata` with `host_err`=0.
- R6: The semaphore is granted before the first bus transfer. It is released with exactly one `sem_rel` pulse after the data access or after a readback timeout, and before `host_ack`.
- R7: A denied lock (`sem_rsp`=1 with `sem_ok`=0) ends the request with `host_err`=1, no bus transfer and no `sem_rel`.
- R8: Requests raised while a request is in progress are ignored. They cause no extra acknowledge and no extra bus transfer.
- R9: After reset, `bus_req`, `sem_acq`, `sem_rel` and `host_ack` are low. Each request produces one `host_ack` pulse that lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Request strobe, sampled in ST_IDLE |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 32 | Indirect register address |
| host_wdata | input | 32 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ack |
| host_err | output | 1 | Error flag, valid with host_ack |
| sem_acq | output | 1 | Semaphore lock request, held until sem_rsp |
| sem_rsp | input | 1 | Semaphore answer strobe |
| sem_ok | input | 1 | Lock granted when sem_rsp is high |
| sem_rel | output | 1 | One-cycle semaphore release |
| bus_req | output | 1 | Bus transfer request, held until bus_ack |
| bus_wr | output | 1 | Bus transfer direction |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus transfer completion |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The bench builds the bridge with `MAX_TRIES`=4 and `POLL_WAIT`=3. These values make a readback that matches only on the final attempt, and a full timeout, reachable in a few dozen cycles. They also make the per-miss latency of `POLL_WAIT`+2 cycles easy to measure. `SEG_COUNT` and `WIN_ADDR` stay at their defaults, so the whole 64-entry map, both kinds of hole, and the out-of-range indices are all exercised.

// File: rtl/iwb_pkg.sv
package iwb_pkg;

    localparam int WORD_W    = 32;
    localparam int SEG_LSB   = 20;
    localparam int SEG_IDX_W = WORD_W - SEG_LSB;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DECODE,
        ST_LOCK,
        ST_WIN_WR,
        ST_WIN_RD,
        ST_WAIT,
        ST_DATA,
        ST_UNLOCK,
        ST_DONE
    } iwb_state_e;

    // Holes: entry zero and every entry whose low three bits are all ones.
    function automatic logic seg_defined(int unsigned idx);
        return (idx != 0) && ((idx % 8) != 7);
    endfunction

    function automatic logic [WORD_W-1:0] seg_base(int unsigned idx);
        return 32'h3000_0000 | (WORD_W'(idx) << SEG_LSB);
    endfunction

endpackage

// File: rtl/iwb_seg_map.sv
module iwb_seg_map
    import iwb_pkg::*;
#(
    parameter int SEG_COUNT = 64
) (
    input  logic [SEG_IDX_W-1:0] seg_idx,
    output logic                 seg_ok,
    output logic [WORD_W-1:0]    seg_base_o
);
    localparam int SEL_W = $clog2(SEG_COUNT);

    logic [WORD_W-1:0] base_tbl [SEG_COUNT];
    logic              def_tbl  [SEG_COUNT];

    generate
        for (genvar g = 0; g < SEG_COUNT; g++) begin : g_entry
            assign base_tbl[g] = seg_base(g);
            assign def_tbl[g]  = seg_defined(g);
        end
    endgenerate

    logic             in_range;
    logic [SEL_W-1:0] sel;

    assign in_range   = (seg_idx < SEG_IDX_W'(SEG_COUNT));
    assign sel        = seg_idx[SEL_W-1:0];
    assign seg_ok     = in_range && def_tbl[sel];
    assign seg_base_o = base_tbl[sel];

endmodule

// File: rtl/iwb_poll.sv
module iwb_poll #(
    parameter int MAX_TRIES = 100,
    parameter int POLL_WAIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic miss,
    output logic last_try,
    output logic wait_done
);
    localparam int TRY_W  = $clog2(MAX_TRIES + 1);
    localparam int WAIT_W = $clog2(POLL_WAIT + 1);

    logic [TRY_W-1:0]  tries;
    logic [WAIT_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
            gap   <= '0;
        end else if (clear) begin
            tries <= '0;
            gap   <= '0;
        end else if (miss) begin
            tries <= tries + 1'b1;
            gap   <= WAIT_W'(POLL_WAIT - 1);
        end else if (gap != '0) begin
            gap <= gap - 1'b1;
        end
    end

    assign last_try  = (tries == TRY_W'(MAX_TRIES - 1));
    assign wait_done = (gap == '0);

    AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        tries < TRY_W'(MAX_TRIES)) else $error("retry count past limit"); // R4

endmodule

// File: rtl/ind_win_bridge.sv
module ind_win_bridge
    import iwb_pkg::*;
#(
    parameter int               SEG_COUNT     = 64,
    parameter int               MAX_TRIES     = 100,
    parameter int               POLL_WAIT     = 1000,
    parameter logic [31:0]      WIN_ADDR      = 32'h0013_0000,
    parameter logic [31:0]      APERTURE_BASE = 32'h001E_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_req,
    input  logic        host_wr,
    input  logic [31:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic        host_ack,
    output logic [31:0] host_rdata,
    output logic        host_err,
    output logic        sem_acq,
    input  logic        sem_rsp,
    input  logic        sem_ok,
    output logic        sem_rel,
    output logic        bus_req,
    output logic        bus_wr,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);
    localparam int OFS_W = 16;

    iwb_state_e state, state_nx;

    logic [WORD_W-1:0] addr_q, wdata_q, win_q, rdata_q;
    logic              wr_q, err_q, lock_held, win_matched;

    logic              seg_ok;
    logic [WORD_W-1:0] seg_base_w;
    logic              last_try, wait_done, poll_clear, poll_miss;
    logic              win_hit;

    iwb_seg_map #(.SEG_COUNT(SEG_COUNT)) u_map (
        .seg_idx    (addr_q[WORD_W-1:SEG_LSB]),
        .seg_ok     (seg_ok),
        .seg_base_o (seg_base_w)
    );

    assign win_hit    = (bus_rdata == win_q);
    assign poll_clear = (state == ST_WIN_WR);
    assign poll_miss  = (state == ST_WIN_RD) && bus_ack && !win_hit && !last_try;

    iwb_poll #(.MAX_TRIES(MAX_TRIES), .POLL_WAIT(POLL_WAIT)) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (poll_clear),
        .miss      (poll_miss),
        .last_try  (last_try),
        .wait_done (wait_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (host_req) state_nx = ST_DECODE;
            ST_DECODE: state_nx = seg_ok ? ST_LOCK : ST_DONE;
            ST_LOCK:   if (sem_rsp) state_nx = sem_ok ? ST_WIN_WR : ST_DONE;
            ST_WIN_WR: if (bus_ack) state_nx = ST_WIN_RD;
            ST_WIN_RD: if (bus_ack) begin
                if (win_hit)       state_nx = ST_DATA;
                else if (last_try) state_nx = ST_UNLOCK;
                else               state_nx = ST_WAIT;
            end
            ST_WAIT:   if (wait_done) state_nx = ST_WIN_RD;
            ST_DATA:   if (bus_ack) state_nx = ST_UNLOCK;
            ST_UNLOCK: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            wr_q        <= 1'b0;
            win_q       <= '0;
            rdata_q     <= '0;
            err_q       <= 1'b0;
            lock_held   <= 1'b0;
            win_matched <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (host_req) begin
                    addr_q      <= host_addr;
                    wdata_q     <= host_wdata;
                    wr_q        <= host_wr;
                    rdata_q     <= '0;
                    err_q       <= 1'b0;
                    win_matched <= 1'b0;
                end
                ST_DECODE: begin
                    if (!seg_ok) err_q <= 1'b1;
                    win_q <= seg_base_w | {12'h000, addr_q[19:16], 16'h0000};
                end
                ST_LOCK: if (sem_rsp) begin
                    if (sem_ok) lock_held <= 1'b1;
                    else        err_q     <= 1'b1;
                end
                ST_WIN_RD: if (bus_ack) begin
                    if (win_hit)       win_matched <= 1'b1;
                    else if (last_try) err_q       <= 1'b1;
                end
                ST_DATA: if (bus_ack && !wr_q) rdata_q <= bus_rdata;
                ST_UNLOCK: lock_held <= 1'b0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        host_ack   = (state == ST_DONE);
        host_rdata = rdata_q;
        host_err   = err_q;
        sem_acq    = (state == ST_LOCK);
        sem_rel    = (state == ST_UNLOCK);
        bus_req    = (state == ST_WIN_WR) || (state == ST_WIN_RD) || (state == ST_DATA);
        bus_wr     = (state == ST_WIN_WR) || ((state == ST_DATA) && wr_q);
        bus_addr   = (state == ST_DATA)
                   ? (APERTURE_BASE | {{(WORD_W-OFS_W){1'b0}}, addr_q[OFS_W-1:0]})
                   : WIN_ADDR;
        bus_wdata  = (state == ST_WIN_WR) ? win_q : (wr_q ? wdata_q : '0);
    end

    AST_BUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> lock_held) else $error("bus used without lock"); // R6
    AST_ACK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !lock_held) else $error("ack while lock held"); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack) else $error("ack longer than a cycle"); // R9
    AST_DATA_AFTER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_addr != WIN_ADDR)) |-> win_matched) else $error("data before match"); // R4
    AST_SEG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || sem_acq) |-> seg_ok) else $error("traffic on bad segment"); // R1
    AST_WIN_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && (bus_addr == WIN_ADDR)) |-> (bus_wdata[19:16] == addr_q[19:16]))
        else $error("window nibble wrong"); // R3

endmodule

// File: tb/tb_ind_win_bridge.sv
module tb_ind_win_bridge;

    localparam int          MAX_TRIES = 4;
    localparam int          POLL_WAIT = 3;
    localparam logic [31:0] WIN_ADDR  = 32'h0013_0000;
    localparam logic [31:0] RD_XOR    = 32'h5A5A_5A5A;
    localparam int          NVEC      = 10;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  lag;
        logic        allow;
        logic        exp_err;
        logic [7:0]  exp_bus;
        logic        exp_rel;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h0015_1234, 32'h0,          8'd0, 1'b1, 1'b0, 8'd3, 1'b1}, // R5 read ok
        '{1'b1, 32'h03E7_ABCD, 32'hDEAD_BEEF,  8'd2, 1'b1, 1'b0, 8'd5, 1'b1}, // R4 two misses
        '{1'b0, 32'h0070_0010, 32'h0,          8'd0, 1'b1, 1'b1, 8'd0, 1'b0}, // R2 hole 7
        '{1'b0, 32'h0000_0044, 32'h0,          8'd0, 1'b1, 1'b1, 8'd0, 1'b0}, // R2 hole 0
        '{1'b1, 32'h0400_0000, 32'h1111_2222,  8'd0, 1'b1, 1'b1, 8'd0, 1'b0}, // R1 idx 0x40
        '{1'b0, 32'hFFF0_0000, 32'h0,          8'd0, 1'b1, 1'b1, 8'd0, 1'b0}, // R1 idx 0xFFF
        '{1'b0, 32'h0023_0008, 32'h0,          8'd3, 1'b1, 1'b0, 8'd6, 1'b1}, // R4 last try hits
        '{1'b0, 32'h0031_0000, 32'h0,          8'd4, 1'b1, 1'b1, 8'd5, 1'b1}, // R4 timeout
        '{1'b1, 32'h0029_FFFF, 32'hCAFE_F00D,  8'd0, 1'b0, 1'b1, 8'd0, 1'b0}, // R7 denied
        '{1'b1, 32'h03FF_0000, 32'h0,          8'd0, 1'b1, 1'b1, 8'd0, 1'b0}  // R2 hole 0x3F
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic        host_ack, host_err;
    logic [31:0] host_rdata;
    logic        sem_acq, sem_rel, bus_req, bus_wr;
    logic        sem_rsp, sem_ok, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    ind_win_bridge #(.MAX_TRIES(MAX_TRIES), .POLL_WAIT(POLL_WAIT), .WIN_ADDR(WIN_ADDR)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ack(host_ack), .host_rdata(host_rdata), .host_err(host_err),
        .sem_acq(sem_acq), .sem_rsp(sem_rsp), .sem_ok(sem_ok), .sem_rel(sem_rel),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // Responder state (driven only here)
    int          bus_cnt, win_rd_cnt, data_cnt, rel_cnt;
    logic        held, viol;
    logic [31:0] win_reg, last_addr, last_wdata;
    // Responder configuration (driven only by the stimulus)
    int          rd_base = 0, lag_cfg = 0;
    logic        sem_allow = 1'b1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_rdata <= '0; sem_rsp <= 1'b0; sem_ok <= 1'b0;
            bus_cnt <= 0; win_rd_cnt <= 0; data_cnt <= 0; rel_cnt <= 0;
            held <= 1'b0; viol <= 1'b0; win_reg <= '0; last_addr <= '0; last_wdata <= '0;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                bus_cnt <= bus_cnt + 1;
                if (!held) viol <= 1'b1;
                if (bus_addr == WIN_ADDR) begin
                    if (bus_wr) win_reg <= bus_wdata;
                    else begin
                        win_rd_cnt <= win_rd_cnt + 1;
                        bus_rdata  <= ((win_rd_cnt - rd_base) < lag_cfg) ? (win_reg ^ 32'h1) : win_reg;
                    end
                end else begin
                    data_cnt   <= data_cnt + 1;
                    last_addr  <= bus_addr;
                    last_wdata <= bus_wdata;
                    bus_rdata  <= bus_addr ^ RD_XOR;
                end
            end
            sem_rsp <= sem_acq && !sem_rsp;
            sem_ok  <= sem_allow;
            if (sem_acq && sem_rsp && sem_ok) held <= 1'b1;
            if (sem_rel) begin
                held    <= 1'b0;
                rel_cnt <= rel_cnt + 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0, cycles = 0;
    logic done_flag = 1'b0;

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000 && !done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", cycles, 0);
            finish_run();
        end
    end

    // Issue one request and wait for its acknowledge.
    task automatic do_req(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                          output logic err, output logic [31:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ack && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        check(host_ack, "R9 ack seen", {31'b0, host_ack}, 32'h1);
        err = host_err;
        rd  = host_rdata;
        @(negedge clk);
        check(!host_ack, "R9 ack one cycle", {31'b0, host_ack}, 32'h0);
    endtask

    initial begin
        logic        err;
        logic [31:0] rd;
        int          lat, lat0, b0, r0, d0;

        repeat (3) @(negedge clk);
        // R9 reset state
        check(!bus_req && !sem_acq && !sem_rel && !host_ack, "R9 reset outputs",
              {28'b0, bus_req, sem_acq, sem_rel, host_ack}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!bus_req && !host_ack, "R9 idle after reset", {30'b0, bus_req, host_ack}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [31:0] ap, ew;
            v = VECS[i];
            rd_base = win_rd_cnt; lag_cfg = int'(v.lag); sem_allow = v.allow;
            b0 = bus_cnt; r0 = rel_cnt; d0 = data_cnt;
            do_req(v.wr, v.addr, v.wdata, err, rd, lat);
            ap = {16'h001E, v.addr[15:0]};
            ew = 32'h3000_0000 | ({20'h0, v.addr[31:20]} << 20) | ({28'h0, v.addr[19:16]} << 16);
            check(err == v.exp_err, "R1 R2 R4 R7 error flag", {31'b0, err}, {31'b0, v.exp_err});
            check((bus_cnt - b0) == int'(v.exp_bus), "R1 R4 R7 bus transfer count",
                  32'(bus_cnt - b0), {24'b0, v.exp_bus});
            check((rel_cnt - r0) == int'(v.exp_rel), "R6 R7 release count",
                  32'(rel_cnt - r0), {31'b0, v.exp_rel});
            check(!held, "R6 lock free at ack", {31'b0, held}, 32'h0);
            if (v.exp_bus != 0)
                check(win_reg == ew, "R2 R3 window value", win_reg, ew);
            if (!v.exp_err) begin
                check((data_cnt - d0) == 1 && last_addr == ap, "R5 aperture address", last_addr, ap);
                if (v.wr) check(last_wdata == v.wdata, "R5 write data", last_wdata, v.wdata);
                else      check(rd == (ap ^ RD_XOR), "R5 read data", rd, ap ^ RD_XOR);
            end else begin
                check((data_cnt - d0) == 0, "R4 no data access on error", 32'(data_cnt - d0), 32'h0);
            end
        end

        // R4 poll gap: one miss adds a read and POLL_WAIT idle cycles
        rd_base = win_rd_cnt; lag_cfg = 0; sem_allow = 1'b1;
        do_req(1'b0, 32'h0011_0000, 32'h0, err, rd, lat0);
        rd_base = win_rd_cnt; lag_cfg = 1;
        do_req(1'b0, 32'h0011_0000, 32'h0, err, rd, lat);
        check(lat - lat0 == POLL_WAIT + 2, "R4 poll gap latency", 32'(lat - lat0), 32'(POLL_WAIT + 2));

        // R8 request raised while busy is ignored
        rd_base = win_rd_cnt; lag_cfg = 2;
        b0 = bus_cnt; d0 = data_cnt;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 32'h0015_0040;
        @(negedge clk);
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        host_req = 1'b1; host_addr = 32'h0016_0080;
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_ack && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
        lat = 0;
        repeat (30) begin
            @(negedge clk);
            if (host_ack) lat++;
        end
        check(lat == 0, "R8 no second ack", 32'(lat), 32'h0);
        check((bus_cnt - b0) == 5, "R8 no extra bus traffic", 32'(bus_cnt - b0), 32'd5);
        check(last_addr == 32'h001E_0040, "R8 first request served", last_addr, 32'h001E_0040);

        check(!viol, "R6 bus only under lock", {31'b0, viol}, 32'h0);
        done_flag = 1'b1;
        finish_run();
    end

endmodule